// File: doc/BRIEF.md
# Restartable Frequency Counter Controller

The block measures the frequency of a measured clock relative to a reference clock. Software writes one 8-bit control byte. The byte picks the measured source, which is either an LC oscillator or a divider output. It also picks the reference source that defines the gating interval, and it can start a measurement. While a measurement runs, the block counts strobes of the measured source. The interval ends after a fixed number of strobes of the reference source. At that point the busy flag drops, the count is latched into a result register, and the done flag rises. The done flag is the level-sensitive interrupt.

A write of 1 to the busy bit restarts the measurement at any moment and throws away any partial count. The done flag can also be written directly, so software can raise the interrupt without running a measurement. Every clock is modelled as a one-cycle enable strobe in the single `clk` domain.

The block has no streaming data path. All pins are plain control or status signals, so there is no valid/ready handshake and no back-pressure. The control byte is written with `reg_wr_en` and read back combinationally on `reg_rd_data` at all times.

Top module: `freq_meter_ctrl`

## Requirements
- R1: After reset, every control field reads 0. The interrupt, both source enables and the result are also 0.
- R2: While busy, each strobe of the enabled measured source adds one to the count. On the INTERVAL-th strobe of the selected reference (default 256), busy clears. The count is then latched into `meas_result`, and it includes any measured strobe in that final cycle.
- R3: Mode field (bits 2:0) to reference mapping: 001 selects `ref_stb[0]` (GPIO reference), 010 selects `ref_stb[1]` (undivided 24 MHz oscillator), 011 selects `ref_stb[2]` (divided system clock), 100 selects `ref_stb[3]` (crystal), 110 selects `ref_stb[4]` (sleep timer).
- R4: The done flag (bit 7) is set when busy (bit 6) falls at the end of a measurement. `irq` equals done and stays high until software writes it.
- R5: A write with bit 6 = 1 and a valid mode in the same byte starts a measurement. If one is running, it restarts it from zero and discards the partial count. A write with bit 6 = 0 leaves busy unchanged.
- R6: A start write clears done. This takes priority over the value of bit 7 in the same write.
- R7: Any write that does not start a measurement loads bit 7 into done, so writing 1 raises `irq`. If a write of done lands in the same cycle as the end-of-measurement set, the hardware set wins.
- R8: Bit 5 = 0 enables `lc_en` and bit 5 = 1 enables `div_en`. Both enables are 0 when the mode is 000. Only the enabled source is counted.
- R9: Bits 4:3 always read 0, and values written to them are ignored.
- R10: A write with bit 6 = 1 and mode 000, 101 or 111 does not start a count. Busy stays 0, and done is not set.
- R11: The measured-edge count saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control byte write strobe |
| reg_wr_data | input | 8 | Control byte write value |
| reg_rd_data | output | 8 | Control byte readback |
| ref_stb | input | 5 | Reference source strobes (index per R3) |
| lc_stb | input | 1 | LC oscillator strobe |
| div_stb | input | 1 | Divider output strobe |
| lc_en | output | 1 | LC oscillator enable |
| div_en | output | 1 | Divider enable |
| meas_result | output | CNT_W | Latched measurement result |
| irq | output | 1 | Level interrupt (done) |

## Verification
The bench targets a software write of done that lands exactly on the cycle that ends a measurement. A design with the wrong priority would lose the interrupt. It also restarts a measurement mid-count; a design that kept the partial count would report more than the interval allows. It tries start writes with disabled and reserved modes, which a careless decoder would accept and then hang busy. Finally, it runs a slow reference against a fast measured clock, where a wrapping counter would report a small number instead of the saturated maximum.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  localparam int NUM_REF = 5;
  localparam int REF_IW  = 3;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'b000,
    MODE_GPIO  = 3'b001,
    MODE_OSC   = 3'b010,
    MODE_SYS   = 3'b011,
    MODE_XTAL  = 3'b100,
    MODE_RSV_A = 3'b101,
    MODE_SLEEP = 3'b110,
    MODE_RSV_B = 3'b111
  } fmc_mode_e;

  // Modes that name a real reference source
  function automatic logic mode_valid(input logic [2:0] m);
    case (m)
      MODE_GPIO, MODE_OSC, MODE_SYS, MODE_XTAL, MODE_SLEEP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Position of the selected reference in the strobe vector
  function automatic logic [REF_IW-1:0] ref_index(input logic [2:0] m);
    case (m)
      MODE_GPIO:  return 3'd0;
      MODE_OSC:   return 3'd1;
      MODE_SYS:   return 3'd2;
      MODE_XTAL:  return 3'd3;
      MODE_SLEEP: return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/fmc_regs.sv
module fmc_regs
  import fmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       done_set,
  input  logic       busy,
  output logic [2:0] mode,
  output logic       src_sel,
  output logic       start,
  output logic       done,
  output logic [7:0] rd_data
);

  localparam int B_DONE = 7;
  localparam int B_BUSY = 6;
  localparam int B_SEL  = 5;

  logic [2:0] mode_q;
  logic       sel_q;
  logic       done_q;

  // Start only when the byte being written carries a usable mode
  assign start = wr_en && wr_data[B_BUSY] && mode_valid(wr_data[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'b000;
      sel_q  <= 1'b0;
    end else if (wr_en) begin
      mode_q <= wr_data[2:0];
      sel_q  <= wr_data[B_SEL];
    end
  end

  // Priority: hardware set, then start clear, then software value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (done_set) done_q <= 1'b1;
    else if (start)    done_q <= 1'b0;
    else if (wr_en)    done_q <= wr_data[B_DONE];
  end

  assign mode    = mode_q;
  assign src_sel = sel_q;
  assign done    = done_q;
  assign rd_data = {done_q, busy, sel_q, 2'b00, mode_q};

  a_r7_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done_q);

  a_r6_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !done_set) |=> !done_q);

  a_r7_sw_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !start && !done_set) |=> (done_q == $past(wr_data[B_DONE])));

endmodule

// File: rtl/fmc_interval.sv
module fmc_interval
  import fmc_pkg::*;
#(
  parameter int INTERVAL = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         mode,
  input  logic [NUM_REF-1:0] ref_stb,
  output logic               busy,
  output logic               finish
);

  localparam int IW = $clog2(INTERVAL + 1);
  localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);

  logic [NUM_REF-1:0] hit_vec;
  logic               ref_hit;
  logic [IW-1:0]      cnt_q;
  logic               busy_q;

  genvar g;
  generate
    for (g = 0; g < NUM_REF; g++) begin : g_ref_mux
      assign hit_vec[g] = ref_stb[g] && mode_valid(mode) &&
                          (ref_index(mode) == REF_IW'(g));
    end
  endgenerate

  assign ref_hit = busy_q && (|hit_vec);
  assign finish  = ref_hit && (cnt_q == LAST) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (finish) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ref_hit) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy = busy_q;

  a_r5_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && cnt_q == '0));

  a_r10_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> !busy_q);

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));

endmodule

// File: rtl/fmc_edge_cnt.sv
module fmc_edge_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic             latch,
  output logic [CNT_W-1:0] result
);

  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] res_q;

  // Saturating increment
  assign cnt_nx = (inc && cnt_q != MAXV) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else            cnt_q <= cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     res_q <= '0;
    else if (latch) res_q <= cnt_nx;
  end

  assign result = res_q;

  a_r11_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && cnt_q == MAXV) |=> (cnt_q == MAXV));

  a_r2_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(res_q));

endmodule

// File: rtl/freq_meter_ctrl.sv
module freq_meter_ctrl
  import fmc_pkg::*;
#(
  parameter int INTERVAL = 256,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [7:0]       reg_wr_data,
  output logic [7:0]       reg_rd_data,
  input  logic [4:0]       ref_stb,
  input  logic             lc_stb,
  input  logic             div_stb,
  output logic             lc_en,
  output logic             div_en,
  output logic [CNT_W-1:0] meas_result,
  output logic             irq
);

  logic [2:0] mode;
  logic       src_sel;
  logic       start;
  logic       done;
  logic       busy;
  logic       finish;
  logic       meas_hit;
  logic       src_on;

  fmc_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_data  (reg_wr_data),
    .done_set (finish),
    .busy     (busy),
    .mode     (mode),
    .src_sel  (src_sel),
    .start    (start),
    .done     (done),
    .rd_data  (reg_rd_data)
  );

  fmc_interval #(.INTERVAL(INTERVAL)) u_interval (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .ref_stb (ref_stb),
    .busy    (busy),
    .finish  (finish)
  );

  assign src_on   = (mode != MODE_OFF);
  assign lc_en    = src_on && !src_sel;
  assign div_en   = src_on &&  src_sel;
  assign meas_hit = busy && ((lc_en && lc_stb) || (div_en && div_stb));

  fmc_edge_cnt #(.CNT_W(CNT_W)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start),
    .inc    (meas_hit),
    .latch  (finish),
    .result (meas_result)
  );

  assign irq = done;

  a_r4_fall_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  a_r8_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lc_en, div_en}));

endmodule

// File: tb/freq_meter_ctrl_bench.sv
module freq_meter_ctrl_bench;

  localparam int CLK_P    = 10;
  localparam int INTERVAL = 256;
  localparam int CNT_W    = 10;
  localparam int MAXV     = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr_en = 1'b0;
  logic [7:0]       reg_wr_data = 8'h00;
  logic [7:0]       reg_rd_data;
  logic [4:0]       ref_stb = '0;
  logic             lc_stb = 1'b0;
  logic             div_stb = 1'b0;
  logic             lc_en, div_en, irq;
  logic [CNT_W-1:0] meas_result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int ref_per [5];
  int lc_per  = 0;
  int div_per = 0;
  int cyc     = 0;

  // reference model state
  int m_mode, m_sel, m_busy, m_done, m_refcnt, m_edge, m_result;
  int idx, enext;
  bit vld, ref_hit, meas_hit, start, fin;

  freq_meter_ctrl #(.INTERVAL(INTERVAL), .CNT_W(CNT_W)) u_freq_meter_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .ref_stb(ref_stb), .lc_stb(lc_stb), .div_stb(div_stb),
    .lc_en(lc_en), .div_en(div_en), .meas_result(meas_result), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit valid_mode(input int m);
    return (m == 1 || m == 2 || m == 3 || m == 4 || m == 6);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // strobe generators
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < 5; i++)
      ref_stb[i] <= (ref_per[i] != 0) && (cyc % ref_per[i] == 0);
    lc_stb  <= (lc_per  != 0) && (cyc % lc_per  == 0);
    div_stb <= (div_per != 0) && (cyc % div_per == 0);
  end

  // cycle-by-cycle behavioural model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_sel = 0; m_busy = 0; m_done = 0;
      m_refcnt = 0; m_edge = 0; m_result = 0;
    end else begin
      vld = valid_mode(m_mode);
      case (m_mode)
        1: idx = 0; 2: idx = 1; 3: idx = 2; 4: idx = 3; 6: idx = 4; default: idx = 0;
      endcase
      ref_hit  = m_busy && vld && ref_stb[idx];
      meas_hit = m_busy && (m_mode != 0) && (m_sel ? div_stb : lc_stb);
      start    = reg_wr_en && reg_wr_data[6] && valid_mode(int'(reg_wr_data[2:0]));
      fin      = ref_hit && (m_refcnt == INTERVAL - 1) && !start;
      enext    = m_edge + int'(meas_hit);
      if (enext > MAXV) enext = MAXV;
      if (fin) m_done = 1;
      else if (start) m_done = 0;
      else if (reg_wr_en) m_done = reg_wr_data[7];
      if (start) begin
        m_busy = 1; m_refcnt = 0; m_edge = 0;
      end else if (fin) begin
        m_busy = 0; m_refcnt = 0; m_result = enext; m_edge = enext;
      end else begin
        if (ref_hit) m_refcnt++;
        m_edge = enext;
      end
      if (reg_wr_en) begin
        m_mode = reg_wr_data[2:0];
        m_sel  = reg_wr_data[5];
      end
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check("R4 done bit", reg_rd_data[7], m_done);
      check("R4 irq level", irq, m_done);
      check("R5 busy bit", reg_rd_data[6], m_busy);
      check("R8 select bit", reg_rd_data[5], m_sel);
      check("R9 reserved bits", reg_rd_data[4:3], 0);
      check("R3 mode field", reg_rd_data[2:0], m_mode);
      check("R8 lc_en", lc_en, (m_mode != 0) && !m_sel);
      check("R8 div_en", div_en, (m_mode != 0) && m_sel);
      check("R2 result", meas_result, m_result);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (reg_rd_data[6] && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic only_ref(input int k, input int per);
    for (int i = 0; i < 5; i++) ref_per[i] = 0;
    ref_per[k] = per;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) ref_per[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_data", reg_rd_data, 0);
    check("R1 irq", irq, 0);
    check("R1 enables", {lc_en, div_en}, 0);
    check("R1 result", meas_result, 0);

    // R9 reserved bits
    wr(8'h18);
    check("R9 reserved ignored", reg_rd_data, 8'h00);

    // R10 start with off / reserved modes
    wr(8'h45);
    check("R10 mode101 no start", reg_rd_data, 8'h05);
    wr(8'h47);
    check("R10 mode111 no start", reg_rd_data, 8'h07);
    wr(8'h40);
    check("R10 mode000 no start", reg_rd_data, 8'h00);
    check("R8 off mode enables", {lc_en, div_en}, 0);

    // R7 forced interrupt
    wr(8'h80);
    check("R7 forced irq", irq, 1);
    wr(8'h00);
    check("R7 irq cleared", irq, 0);

    // R3 each mode picks its own reference strobe
    lc_per = 1;
    foreach (ref_per[k]) begin
      int md;
      case (k) 0: md = 1; 1: md = 2; 2: md = 3; 3: md = 4; default: md = 6; endcase
      only_ref(k, 1);
      wr(8'h40 | 8'(md));
      check("R6 start clears done", reg_rd_data[7], 0);
      wait_idle();
      @(negedge clk);
      check("R3 mode result", meas_result, INTERVAL);
      check("R4 irq after run", irq, 1);
    end

    // R8 divider source
    only_ref(0, 1); lc_per = 1; div_per = 3;
    wr(8'h61);
    check("R8 div selected", {lc_en, div_en}, 2'b01);
    wait_idle();
    @(negedge clk);
    check("R8 div count bounded", int'(meas_result <= 86 && meas_result >= 85), 1);

    // R5 restart discards partial count; write of busy=0 has no effect
    div_per = 0;
    wr(8'h41);
    repeat (60) @(negedge clk);
    wr(8'h01);
    check("R5 busy unaffected by 0", reg_rd_data[6], 1);
    repeat (40) @(negedge clk);
    wr(8'h41);
    wait_idle();
    @(negedge clk);
    check("R5 restart result", meas_result, INTERVAL);

    // R7 hardware set wins over a same-cycle done clear
    wr(8'h41);
    repeat (INTERVAL - 1) @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = 8'h01;
    @(negedge clk);
    reg_wr_en = 1'b0;
    check("R7 hw set wins", irq, 1);
    check("R4 busy dropped", reg_rd_data[6], 0);

    // R6 start clear beats done bit in same write
    wr(8'hC1);
    check("R6 start beats done write", reg_rd_data[7:6], 2'b01);
    wait_idle();

    // R11 saturation
    only_ref(0, 8); lc_per = 1;
    wr(8'h41);
    wait_idle();
    @(negedge clk);
    check("R11 saturated result", meas_result, MAXV);

    // R1 reset mid-operation
    wr(8'h41);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset rd_data", reg_rd_data, 0);
    check("R1 reset result", meas_result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule